// File: doc/BRIEF.md
# Double-Buffered 10-bit Pulse-Width Modulator

This block produces a pulse-width modulated signal from an 8-bit up-counting period timer. The timer is extended downward by a 2-bit fine count, so the compare that ends each pulse works on 10 bits. A programmable prescaler sets how many clock-enable ticks make up one fine step. Software programs the block through a small register-write port that covers the period limit, the upper 8 bits of the duty value, and a control byte. The control byte holds the two lowest duty bits, the output-mode field and the prescaler select.

The duty value is double-buffered. Writes land in a staging copy at any time. The staging copy is moved into the active compare register only at the end of a period, so a pulse is never cut short or stretched by a write in mid-period. The active duty value and the mode field are brought out for read-back.

Of the four output-mode encodings, only the single-output setting drives the PWM pin. The other three are stored and read back, and they keep the output low.

Top module: `pwm10_dbuf`

## Requirements
- R1: While reset is high and after it is released, `pwm_out` is 0, `duty_rd` is 0 and `mode_rd` is 0 (single).
- R2: A write with `wr_en` high stores `wr_data` according to `wr_addr`. Address 0 sets the 8-bit period limit. Address 1 sets the upper 8 duty bits. Address 2 sets the control byte: bits [1:0] are the lowest duty bits, bits [3:2] are the output mode and bits [5:4] are the prescaler select. A write to address 3 changes nothing.
- R3: `duty_rd` shows the active duty value. It takes the staged value only at a period end, so a write made during a period does not affect that period. During the first period after reset, the active value is 0.
- R4: Fine steps occur once every P ticks of `ce`. P is 1 for select 00, 4 for select 01 and 16 for select 10 or 11. Four fine steps make one timer count. A period lasts 4·P·(period+1) ticks of `ce`, after which the timer and the fine count restart at 0.
- R5: In single mode with an active duty value D, the output goes high when a period starts. It goes low when the 10-bit count {timer, fine} reaches D, so it stays high for exactly D fine steps.
- R6: An active duty value of 0 keeps the output low for the whole period.
- R7: An active duty value above 4·period+3 is never matched, so the output stays high for the whole period.
- R8: While `ce` is low, the counters, `pwm_out` and `duty_rd` hold their values.
- R9: Mode 00 is single output. Modes 01, 10 and 11 hold `pwm_out` low, and `mode_rd` reports the stored mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce | input | 1 | Tick enable for the prescaler and the counters |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 period, 1 duty upper, 2 control, 3 unused |
| wr_data | input | 8 | Write data |
| pwm_out | output | 1 | Registered PWM output |
| duty_rd | output | 10 | Active (loaded) duty value |
| mode_rd | output | 2 | Stored output-mode field |

## Verification
The bench sweeps every duty value from 0 to two counts past the last reachable count, for several small period limits and for each prescaler setting. It checks the output on every tick against arithmetic on the tick count. An off-by-one in the compare would lengthen or shorten each pulse by one fine step. A wrong prescaler decode would shift every edge, and a missed overflow case would drop the output where it should stay high.

A duty write made in mid-period must leave that period untouched and show up only in the next one. A design without the double buffer would change both the read-back and the pulse at once. The bench also covers a stall of `ce` while the output is high, a write to the unused address, and the three non-single modes, each of which must keep the output low.

// File: rtl/pwm10_pkg.sv
package pwm10_pkg;

  typedef enum logic [1:0] {
    MODE_SINGLE = 2'b00,
    MODE_HALF   = 2'b01,
    MODE_FWD    = 2'b10,
    MODE_REV    = 2'b11
  } out_mode_e;

  typedef enum logic [1:0] {
    ADDR_PERIOD  = 2'd0,
    ADDR_DUTY_HI = 2'd1,
    ADDR_CTRL    = 2'd2,
    ADDR_SPARE   = 2'd3
  } reg_addr_e;

  // last prescaler count before a fine step: divide by 1, 4 or 16
  function automatic int unsigned presc_last(input logic [1:0] sel);
    case (sel)
      2'b00:   return 0;
      2'b01:   return 3;
      default: return 15;
    endcase
  endfunction

endpackage

// File: rtl/pwm10_regs.sv
module pwm10_regs
  import pwm10_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int FRAC_W = 2,
  localparam int DUTY_W = CNT_W + FRAC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  output logic [CNT_W-1:0]  period_q,
  output logic [DUTY_W-1:0] duty_stage_q,
  output out_mode_e         mode_q,
  output logic [1:0]        presc_q
);

  localparam int MODE_LSB  = FRAC_W;
  localparam int PRESC_LSB = FRAC_W + 2;

  always_ff @(posedge clk) begin
    if (rst) begin
      period_q     <= '0;
      duty_stage_q <= '0;
      mode_q       <= MODE_SINGLE;
      presc_q      <= '0;
    end else if (wr_en) begin
      case (reg_addr_e'(wr_addr))
        ADDR_PERIOD:  period_q <= wr_data;
        ADDR_DUTY_HI: duty_stage_q[DUTY_W-1:FRAC_W] <= wr_data;
        ADDR_CTRL: begin
          duty_stage_q[FRAC_W-1:0] <= wr_data[FRAC_W-1:0];
          mode_q  <= out_mode_e'(wr_data[MODE_LSB +: 2]);
          presc_q <= wr_data[PRESC_LSB +: 2];
        end
        default: ;
      endcase
    end
  end

  AST_SPARE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == ADDR_SPARE) |=> ($stable(period_q) && $stable(duty_stage_q)
      && $stable(mode_q) && $stable(presc_q))); // R2

endmodule

// File: rtl/pwm10_timebase.sv
module pwm10_timebase
  import pwm10_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int FRAC_W = 2,
  parameter int PRE_W  = 4,
  localparam int DUTY_W = CNT_W + FRAC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce,
  input  logic [1:0]        presc_sel,
  input  logic [CNT_W-1:0]  period,
  output logic              step,
  output logic              wrap,
  output logic [DUTY_W-1:0] cnt_next
);

  logic [PRE_W-1:0]  pcnt_q;
  logic [PRE_W-1:0]  pre_last;
  logic [DUTY_W-1:0] cnt_q;
  logic              at_end;

  always_comb pre_last = PRE_W'(presc_last(presc_sel));

  assign step   = ce && (pcnt_q >= pre_last);
  assign at_end = (cnt_q[DUTY_W-1:FRAC_W] == period) && (&cnt_q[FRAC_W-1:0]);
  assign wrap   = step && at_end;

  always_comb begin
    if (wrap)      cnt_next = '0;
    else if (step) cnt_next = cnt_q + 1'b1;
    else           cnt_next = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pcnt_q <= '0;
      cnt_q  <= '0;
    end else if (ce) begin
      pcnt_q <= step ? '0 : pcnt_q + 1'b1;
      cnt_q  <= cnt_next;
    end
  end

  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (cnt_q == '0)); // R4

  AST_FROZEN_COUNT: assert property (@(posedge clk) disable iff (rst)
    !ce |=> ($stable(cnt_q) && $stable(pcnt_q))); // R8

endmodule

// File: rtl/pwm10_outstage.sv
module pwm10_outstage
  import pwm10_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int FRAC_W = 2,
  localparam int DUTY_W = CNT_W + FRAC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic              wrap,
  input  logic [DUTY_W-1:0] cnt_next,
  input  logic [DUTY_W-1:0] duty_stage,
  input  out_mode_e         mode,
  output logic              pwm_q,
  output logic [DUTY_W-1:0] duty_act_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      duty_act_q <= '0;
      pwm_q      <= 1'b0;
    end else begin
      if (wrap) duty_act_q <= duty_stage;
      if (mode != MODE_SINGLE)                   pwm_q <= 1'b0;
      else if (wrap)                             pwm_q <= (duty_stage != '0);
      else if (step && cnt_next == duty_act_q)   pwm_q <= 1'b0;
    end
  end

  AST_DUTY_HELD: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(duty_act_q)); // R3

  AST_CLEAR_ON_MATCH: assert property (@(posedge clk) disable iff (rst)
    (step && !wrap && cnt_next == duty_act_q) |=> !pwm_q); // R5

  AST_ZERO_DUTY_LOW: assert property (@(posedge clk) disable iff (rst)
    (duty_act_q == '0) |-> !pwm_q); // R6

  AST_OTHER_MODES_LOW: assert property (@(posedge clk) disable iff (rst)
    (mode != MODE_SINGLE) |=> !pwm_q); // R9

endmodule

// File: rtl/pwm10_dbuf.sv
module pwm10_dbuf
  import pwm10_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int FRAC_W = 2,
  parameter int PRE_W  = 4,
  localparam int DUTY_W = CNT_W + FRAC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  output logic              pwm_out,
  output logic [DUTY_W-1:0] duty_rd,
  output logic [1:0]        mode_rd
);

  logic [CNT_W-1:0]  period_q;
  logic [DUTY_W-1:0] duty_stage_q;
  out_mode_e         mode_q;
  logic [1:0]        presc_q;
  logic              step;
  logic              wrap;
  logic [DUTY_W-1:0] cnt_next;

  pwm10_regs #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .period_q(period_q), .duty_stage_q(duty_stage_q), .mode_q(mode_q), .presc_q(presc_q)
  );

  pwm10_timebase #(.CNT_W(CNT_W), .FRAC_W(FRAC_W), .PRE_W(PRE_W)) u_tb (
    .clk(clk), .rst(rst), .ce(ce), .presc_sel(presc_q), .period(period_q),
    .step(step), .wrap(wrap), .cnt_next(cnt_next)
  );

  pwm10_outstage #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_out (
    .clk(clk), .rst(rst), .step(step), .wrap(wrap), .cnt_next(cnt_next),
    .duty_stage(duty_stage_q), .mode(mode_q), .pwm_q(pwm_out), .duty_act_q(duty_rd)
  );

  assign mode_rd = mode_q;

  AST_IDLE_HOLDS_OUT: assert property (@(posedge clk) disable iff (rst)
    (!ce && mode_q == MODE_SINGLE) |=> ($stable(pwm_out) && $stable(duty_rd))); // R8

endmodule

// File: tb/pwm10_dbuf_test.sv
`timescale 1ns/1ps
module pwm10_dbuf_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ce = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       pwm_out;
  logic [9:0] duty_rd;
  logic [1:0] mode_rd;

  int total = 0;
  int fails = 0;
  int k = 0;
  int cfg_per, cfg_p, cfg_mode;
  int d_old, d_new, n_sw;

  always #5 clk = ~clk;

  pwm10_dbuf uut (
    .clk(clk), .rst(rst), .ce(ce), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwm_out(pwm_out), .duty_rd(duty_rd), .mode_rd(mode_rd)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (k=%0d)", req, act, exp, k);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; ce = 1'b0; wr_en = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    #1 wr_en = 1'b0;
    if (ce) k++;
  endtask

  function automatic int p_of(input int sel);
    return (sel == 0) ? 1 : (sel == 1) ? 4 : 16;
  endfunction

  // R4: fine steps after k ticks, period length in steps 4*(per+1)
  task automatic check_now();
    int steps, len, n, s, dexp, pexp;
    string req;
    steps = k / cfg_p;
    len   = 4 * (cfg_per + 1);
    n     = steps / len;
    s     = steps % len;
    dexp  = (n == 0) ? 0 : ((n < n_sw) ? d_old : d_new);
    pexp  = (cfg_mode == 0 && s < dexp) ? 1 : 0;
    if (n == 0)           req = "R3";
    else if (cfg_mode != 0) req = "R9";
    else if (dexp == 0)   req = "R6";
    else if (dexp >= len) req = "R7";
    else                  req = "R5";
    check(pwm_out == pexp, req, pwm_out, pexp);
    check(duty_rd == dexp, "R3", duty_rd, dexp);
  endtask

  task automatic setup_cfg(input int per, input int duty, input int psel, input int mode);
    do_reset();
    cfg_per = per; cfg_p = p_of(psel); cfg_mode = mode;
    d_old = duty; d_new = duty; n_sw = 1 << 30;
    k = 0;
    wr(2'd0, 8'(per));
    wr(2'd1, 8'(duty >> 2));
    wr(2'd2, 8'((psel << 4) | (mode << 2) | (duty & 3)));
    check(mode_rd == 2'(mode), "R9", mode_rd, mode);
    ce = 1'b1;
  endtask

  task automatic run_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1 k++;
      check_now();
    end
  endtask

  initial begin
    #2ms;
    fails++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    // R1: reset state
    do_reset();
    check(pwm_out == 1'b0, "R1", pwm_out, 0);
    check(duty_rd == 10'd0, "R1", duty_rd, 0);
    check(mode_rd == 2'd0, "R1", mode_rd, 0);

    // R4 R5 R6 R7: sweep duties for small periods, prescale 1 and 4
    for (int ps = 0; ps < 2; ps++)
      for (int per = 0; per < 4; per++)
        for (int d = 0; d <= 4 * (per + 1) + 1; d++) begin
          setup_cfg(per, d, ps, 0);
          run_ticks(3 * 4 * (per + 1) * p_of(ps));
        end

    // R4: prescale 16 (both select codes)
    for (int ps = 2; ps < 4; ps++)
      for (int d = 0; d < 10; d += 3) begin
        setup_cfg(1, d, ps, 0);
        run_ticks(2 * 8 * 16 + 20);
      end

    // R9: non-single modes hold the output low
    for (int m = 1; m < 4; m++) begin
      setup_cfg(2, 5, 0, m);
      run_ticks(3 * 12);
    end

    // R2: write to unused address changes nothing
    setup_cfg(3, 6, 0, 0);
    ce = 1'b0;
    wr(2'd3, 8'hFF);
    ce = 1'b1;
    run_ticks(3 * 16);

    // R3: mid-period write takes effect only at the next period
    setup_cfg(3, 5, 0, 0);
    run_ticks(16 + 3);
    wr(2'd1, 8'd3);            // staged duty becomes 13, k now inside period 1
    check(duty_rd == 10'd5, "R3", duty_rd, 5);
    d_new = 13; n_sw = 2;
    run_ticks(2 * 16);

    // R8: stall with output high, everything holds
    begin
      logic p0;
      logic [9:0] d0;
      p0 = pwm_out; d0 = duty_rd;
      check(p0 == 1'b1, "R8", p0, 1);
      ce = 1'b0;
      for (int i = 0; i < 8; i++) begin
        @(posedge clk);
        #1;
        check(pwm_out == p0, "R8", pwm_out, p0);
        check(duty_rd == d0, "R8", duty_rd, d0);
      end
      ce = 1'b1;
      run_ticks(16);
    end

    // R1: reset mid-run clears outputs
    rst = 1'b1;
    @(posedge clk);
    #1;
    check(pwm_out == 1'b0, "R1", pwm_out, 0);
    check(duty_rd == 10'd0, "R1", duty_rd, 0);
    check(mode_rd == 2'd0, "R1", mode_rd, 0);
    rst = 1'b0;

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule